// File: doc/BRIEF.md
# Banked USB Endpoint Control Registers

This block is the CPU-facing register slice of a small USB device controller that owns several hardware endpoints. The CPU writes an endpoint number into a select register. From then on, every access to the shared control address reaches that endpoint's own copy of the control bits. Each endpoint's copy holds three things: an enable bit, a STALL request bit that software sets and the USB engine clears, and write-one strobes that abort a STALL or reset the data toggle. A separate register holds one FIFO reset bit per endpoint. While an endpoint's bit is set, that endpoint is kept in its reset state.

The CPU side is a plain byte bus with address, write data, write enable and read enable. Read data is registered and appears one clock after the read enable. The USB engine reports two kinds of event, "STALL handshake sent" and "SETUP token received". Each is a one-cycle pulse tagged with an endpoint number, and each drops the pending STALL request of the endpoint it names. Per-endpoint enable, STALL request, in-reset and toggle-clear lines go back to the engine as registered outputs.

Top module: `ep_ctl_regs`

## Requirements
- R1: After the synchronous reset, every register and every output reads zero.
- R2: A write to byte address 0xE9 stores data bits 2:0 as the endpoint select. Reading 0xE9 returns the select in bits 2:0 and zero in bits 7:3. All read data appears on cpu_rdata in the cycle after cpu_re, and cpu_rdata is zero in a cycle that follows no read.
- R3: Address 0xEA holds one FIFO reset bit per endpoint in bits 4:0, with bit i belonging to endpoint i. Bits 7:5 read zero. ep_in_reset mirrors the stored bits from the cycle after the write.
- R4: Accesses to 0xEB reach the endpoint named by the select register. Bit 5 is STALL request, bit 4 is STALL abort, bit 3 is toggle reset and bit 0 is enable. A read returns the STALL request in bit 5 and the enable in bit 0; all other bits read zero.
- R5: Bit 0 of a control write sets or clears the selected endpoint's enable. ep_enable follows in the next cycle.
- R6: Writing one to bit 5 sets the selected endpoint's STALL request. Writing zero to bit 5 leaves it unchanged.
- R7: A "STALL sent" or "SETUP received" pulse tagged with endpoint i clears that endpoint's STALL request in the next cycle. Other endpoints keep theirs.
- R8: When a CPU write sets the STALL request in the same cycle as an engine clear event for the same endpoint, the request ends up set.
- R9: Writing one to bit 4 clears the selected endpoint's STALL request. If bits 4 and 5 are both one in the same write, the clear wins.
- R10: Writing one to bit 3 drives ep_toggle_clr of the selected endpoint high for exactly the next cycle. Bit 3 and bit 4 always read back as zero.
- R11: With a select value of 5, 6 or 7, control reads return zero and control writes change no endpoint.
- R12: While an endpoint's FIFO reset bit is one, its enable and STALL request stay zero, its ep_toggle_clr stays high, and control writes to it have no effect. Once the bit is cleared, control writes to that endpoint work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 8 | Register byte address |
| cpu_wdata | input | 8 | Write data |
| cpu_we | input | 1 | Write enable |
| cpu_re | input | 1 | Read enable |
| cpu_rdata | output | 8 | Registered read data, valid the cycle after cpu_re |
| eng_stall_sent | input | 1 | Pulse: STALL handshake sent |
| eng_stall_ep | input | 3 | Endpoint tag for eng_stall_sent |
| eng_setup_seen | input | 1 | Pulse: SETUP token received |
| eng_setup_ep | input | 3 | Endpoint tag for eng_setup_seen |
| ep_enable | output | 5 | Per-endpoint enable |
| ep_stall_req | output | 5 | Per-endpoint pending STALL request |
| ep_in_reset | output | 5 | Per-endpoint FIFO reset state |
| ep_toggle_clr | output | 5 | Per-endpoint toggle-reset pulse, held high during reset |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. Register state, the per-endpoint outputs and cpu_rdata all settle at the first rising edge after the inputs are applied. A read returns the state as it stood before any write issued in the same cycle, and the forcing by a FIFO reset bit starts one edge after that bit is stored. The bench applies each stimulus on a falling edge and checks all outputs on the following falling edge. It predicts every output from a model advanced by one step for each cycle, so a pulse such as ep_toggle_clr is checked in the single cycle in which it must be high and in the cycle after, when it must be low.

// File: rtl/ep_regs_pkg.sv
package ep_regs_pkg;
  localparam int unsigned EPIDX_W = 3;
  localparam int unsigned BYTE_W  = 8;

  localparam logic [BYTE_W-1:0] ADDR_SEL = 8'hE9;
  localparam logic [BYTE_W-1:0] ADDR_RST = 8'hEA;
  localparam logic [BYTE_W-1:0] ADDR_CTL = 8'hEB;

  localparam int unsigned B_STALL     = 5;
  localparam int unsigned B_STALL_CLR = 4;
  localparam int unsigned B_TOG_RST   = 3;
  localparam int unsigned B_EN        = 0;
endpackage

// File: rtl/ep_bank.sv
module ep_bank
  import ep_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_rst,
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              hw_clr,
  output logic              en_o,
  output logic              stall_o,
  output logic              tog_o
);
  logic en_q, stall_q, tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      stall_q <= 1'b0;
      tog_q   <= 1'b0;
    end else if (in_rst) begin
      en_q    <= 1'b0;
      stall_q <= 1'b0;
      tog_q   <= 1'b1;
    end else begin
      if (ctl_wr) en_q <= wdata[B_EN];
      if (ctl_wr && wdata[B_STALL_CLR])  stall_q <= 1'b0;
      else if (ctl_wr && wdata[B_STALL]) stall_q <= 1'b1;
      else if (hw_clr)                   stall_q <= 1'b0;
      tog_q <= ctl_wr && wdata[B_TOG_RST];
    end
  end

  assign en_o    = en_q;
  assign stall_o = stall_q;
  assign tog_o   = tog_q;

  // R12
  held_rst_chk: assert property (@(posedge clk) disable iff (rst)
    in_rst |=> (!en_q && !stall_q && tog_q));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_rst && ctl_wr && wdata[B_STALL] && !wdata[B_STALL_CLR]) |=> stall_q);

  // R7
  hw_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_rst && hw_clr && !(ctl_wr && wdata[B_STALL])) |=> !stall_q);

  // R10
  tog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_rst && !(ctl_wr && wdata[B_TOG_RST])) |=> !tog_q);
endmodule

// File: rtl/ep_rdmux.sv
module ep_rdmux
  import ep_regs_pkg::*;
#(
  parameter int unsigned NUM_EP = 5
) (
  input  logic [BYTE_W-1:0]  addr,
  input  logic [EPIDX_W-1:0] sel,
  input  logic [NUM_EP-1:0]  rst_bits,
  input  logic [NUM_EP-1:0]  en,
  input  logic [NUM_EP-1:0]  stall,
  output logic [BYTE_W-1:0]  data
);
  logic [BYTE_W-1:0] ctl_word;

  always_comb begin
    ctl_word = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sel == EPIDX_W'(i)) begin
        ctl_word[B_STALL] = stall[i];
        ctl_word[B_EN]    = en[i];
      end
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_SEL: data = BYTE_W'(sel);
      ADDR_RST: data = BYTE_W'(rst_bits);
      ADDR_CTL: data = ctl_word;
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/ep_ctl_regs.sv
module ep_ctl_regs
  import ep_regs_pkg::*;
#(
  parameter int unsigned NUM_EP = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          cpu_addr,
  input  logic [7:0]          cpu_wdata,
  input  logic                cpu_we,
  input  logic                cpu_re,
  output logic [7:0]          cpu_rdata,
  input  logic                eng_stall_sent,
  input  logic [2:0]          eng_stall_ep,
  input  logic                eng_setup_seen,
  input  logic [2:0]          eng_setup_ep,
  output logic [NUM_EP-1:0]   ep_enable,
  output logic [NUM_EP-1:0]   ep_stall_req,
  output logic [NUM_EP-1:0]   ep_in_reset,
  output logic [NUM_EP-1:0]   ep_toggle_clr
);
  logic [EPIDX_W-1:0] sel_q;
  logic [NUM_EP-1:0]  rst_q;
  logic [BYTE_W-1:0]  rd_mux, rdata_q;
  logic               ctl_wr_any;

  assign ctl_wr_any = cpu_we && (cpu_addr == ADDR_CTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      rst_q <= '0;
    end else if (cpu_we) begin
      if (cpu_addr == ADDR_SEL) sel_q <= cpu_wdata[EPIDX_W-1:0];
      if (cpu_addr == ADDR_RST) rst_q <= cpu_wdata[NUM_EP-1:0];
    end
  end

  generate
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      logic hit, clr;
      assign hit = ctl_wr_any && (sel_q == EPIDX_W'(g));
      assign clr = (eng_stall_sent && (eng_stall_ep == EPIDX_W'(g))) ||
                   (eng_setup_seen && (eng_setup_ep == EPIDX_W'(g)));
      ep_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .in_rst  (rst_q[g]),
        .ctl_wr  (hit),
        .wdata   (cpu_wdata),
        .hw_clr  (clr),
        .en_o    (ep_enable[g]),
        .stall_o (ep_stall_req[g]),
        .tog_o   (ep_toggle_clr[g])
      );
    end
  endgenerate

  ep_rdmux #(.NUM_EP(NUM_EP)) u_rdmux (
    .addr     (cpu_addr),
    .sel      (sel_q),
    .rst_bits (rst_q),
    .en       (ep_enable),
    .stall    (ep_stall_req),
    .data     (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (cpu_re) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign cpu_rdata   = rdata_q;
  assign ep_in_reset = rst_q;

  // R2
  sel_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_re && cpu_addr == ADDR_SEL) |=> (cpu_rdata[7:3] == 5'd0));

  // R11
  oob_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_any && sel_q >= EPIDX_W'(NUM_EP) && ep_in_reset == '0) |=> $stable(ep_enable));

  // R3
  rst_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == ADDR_RST) |=> (ep_in_reset == $past(cpu_wdata[NUM_EP-1:0])));
endmodule

// File: tb/ep_ctl_regs_tb.sv
`timescale 1ns/1ps
module ep_ctl_regs_tb;
  localparam int N = 5;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] addr = '0, wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic hs = 1'b0, hu = 1'b0;
  logic [2:0] hs_ep = '0, hu_ep = '0;
  logic [7:0] rdata;
  logic [N-1:0] en_o, st_o, ir_o, tg_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0]   m_sel;
  logic [N-1:0] m_rst, m_en, m_st, m_tg;

  always #4 clk = ~clk;

  ep_ctl_regs #(.NUM_EP(N)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_wdata(wdata), .cpu_we(we), .cpu_re(re),
    .cpu_rdata(rdata), .eng_stall_sent(hs), .eng_stall_ep(hs_ep), .eng_setup_seen(hu),
    .eng_setup_ep(hu_ep), .ep_enable(en_o), .ep_stall_req(st_o), .ep_in_reset(ir_o),
    .ep_toggle_clr(tg_o));

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [7:0] d = '0;
    if (a == 8'hE9) d = {5'd0, m_sel};
    else if (a == 8'hEA) d = 8'(m_rst);
    else if (a == 8'hEB && m_sel < 3'(N)) d = {2'b00, m_st[m_sel], 4'b0000, m_en[m_sel]};
    return d;
  endfunction

  task automatic model_reset();
    m_sel = '0; m_rst = '0; m_en = '0; m_st = '0; m_tg = '0;
  endtask

  task automatic model_step();
    for (int i = 0; i < N; i++) begin
      logic hit;
      hit = we && addr == 8'hEB && m_sel == 3'(i);
      if (m_rst[i]) begin
        m_en[i] = 1'b0; m_st[i] = 1'b0; m_tg[i] = 1'b1;
      end else begin
        if (hit) m_en[i] = wdata[0];
        if (hit && wdata[4]) m_st[i] = 1'b0;
        else if (hit && wdata[5]) m_st[i] = 1'b1;
        else if ((hs && hs_ep == 3'(i)) || (hu && hu_ep == 3'(i))) m_st[i] = 1'b0;
        m_tg[i] = hit && wdata[3];
      end
    end
    if (we && addr == 8'hE9) m_sel = wdata[2:0];
    if (we && addr == 8'hEA) m_rst = wdata[N-1:0];
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [7:0] a, input logic [7:0] d,
                     input logic w, input logic r,
                     input logic s, input logic [2:0] sep, input logic u, input logic [2:0] uep);
    logic [7:0] er;
    addr = a; wdata = d; we = w; re = r; hs = s; hs_ep = sep; hu = u; hu_ep = uep;
    er = r ? exp_read(a) : 8'h00;
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    check(tag, "enable", 32'(en_o), 32'(m_en));
    check(tag, "stall", 32'(st_o), 32'(m_st));
    check(tag, "in_reset", 32'(ir_o), 32'(m_rst));
    check(tag, "toggle_clr", 32'(tg_o), 32'(m_tg));
    check(tag, "rdata", 32'(rdata), 32'(er));
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d);
    cyc(tag, a, d, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0);
  endtask
  task automatic rd(input string tag, input logic [7:0] a);
    cyc(tag, a, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    @(negedge clk);
    cyc("R1", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0);
    rst = 1'b0;
    rd("R1", 8'hE9); rd("R1", 8'hEA); rd("R1", 8'hEB);
    wr("R2", 8'hE9, 8'hFF); rd("R2", 8'hE9);
    wr("R2", 8'hE9, 8'h02);
    wr("R5", 8'hEB, 8'h01); rd("R4", 8'hEB);
    wr("R6", 8'hEB, 8'h21); wr("R6", 8'hEB, 8'h01); rd("R4", 8'hEB);
    cyc("R7", 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0);
    cyc("R7", 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 3'd0);
    wr("R6", 8'hEB, 8'h21);
    cyc("R7", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2);
    cyc("R8", 8'hEB, 8'h21, 1'b1, 1'b0, 1'b1, 3'd2, 1'b1, 3'd2);
    wr("R9", 8'hEB, 8'h11);
    wr("R6", 8'hEB, 8'h21); wr("R9", 8'hEB, 8'h31);
    wr("R10", 8'hEB, 8'h29); rd("R10", 8'hEB); rd("R10", 8'hEB);
    wr("R11", 8'hE9, 8'h06); wr("R11", 8'hEB, 8'h21); rd("R11", 8'hEB);
    wr("R11", 8'hE9, 8'h02); rd("R11", 8'hEB);
    wr("R3", 8'hEA, 8'hFF); rd("R3", 8'hEA);
    wr("R12", 8'hEA, 8'h04); wr("R12", 8'hEB, 8'h29); rd("R12", 8'hEB);
    wr("R12", 8'hEA, 8'h00); wr("R12", 8'hEB, 8'h21); rd("R12", 8'hEB);
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] a, d;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 2) ? 8'hE9 : (pick < 3) ? 8'hEA : (pick < 9) ? 8'hEB : 8'($urandom);
      d = 8'($urandom);
      if (a == 8'hEA && $urandom_range(0, 3) != 0) d = 8'h00;
      cyc("R4", a, d, 1'($urandom), 1'($urandom),
          ($urandom_range(0, 5) == 0), 3'($urandom), ($urandom_range(0, 5) == 0), 3'($urandom));
    end
    finish_run();
  end
endmodule